// File: doc/BRIEF.md
# Single-Level Page Translator with Permission Check

This block turns a 16-bit virtual address into a physical address. It uses a sixteen-entry page table that sits in flip-flops. The upper four address bits, the virtual page number, pick an entry directly. The low twelve bits are the page offset and go through unchanged.

Each entry holds the following fields:
- a valid flag
- a 20-bit physical page number
- three permission flags, one each for read, write and execute
- a flag that marks the page as supervisor-only

Every request carries three things: an address, an access kind and the requester's privilege. The block answers one cycle later with one of two results:
- a 32-bit physical address, or
- a fault with a two-bit cause.

A configuration write port loads one entry per clock. Software uses this port to build the map before it issues lookups. The physical page number is wider than the virtual one, and both sides use a 4 KiB page.

The response stage is a three-state machine:
- IDLE: no response this cycle.
- MAPPED: a translated address is presented.
- FAULTED: a fault and its cause are presented.

The state machine moves on every clock edge, from any state:
- to MAPPED when a request arrives and no check fails;
- to FAULTED when a request arrives and some check fails;
- to IDLE when no request arrives.

Top module: `page_xlate_unit`

## Requirements
- R1: On a successful lookup, `rsp_paddr` equals the entry's 20-bit physical page number in bits 31:12, followed by virtual address bits 11:0 unchanged in bits 11:0.
- R2: Virtual address bits 15:12 select table entry 0 to 15 directly.
- R3: A request whose entry has its valid flag clear faults with cause 1.
- R4: Access code 0 (read) needs the read flag, code 1 (write) needs the write flag and code 2 (execute) needs the execute flag. Code 3 is always refused. A refused access faults with cause 2.
- R5: A request with `req_priv`=0 (user) to an entry whose supervisor-only flag is 1 faults with cause 3. A request with `req_priv`=1 (supervisor) passes this check on any page.
- R6: When several checks fail, the cause reported is the lowest code: not-valid (1) first, then access (2), then privilege (3).
- R7: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high. On success `rsp_fault`=0 and `rsp_cause`=0.
- R8: While `rsp_fault` is high, `rsp_cause` is nonzero and `rsp_paddr` is zero.
- R9: A configuration write takes effect at the clock edge where `cfg_we` is sampled. A lookup sampled at that same edge sees the old entry.
- R10: Reset clears every entry's valid flag and drives `rsp_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load one table entry |
| cfg_idx | input | 4 | Entry to load |
| cfg_valid | input | 1 | Valid flag to store |
| cfg_ppn | input | 20 | Physical page number to store |
| cfg_rd | input | 1 | Read permitted |
| cfg_wr | input | 1 | Write permitted |
| cfg_ex | input | 1 | Execute permitted |
| cfg_sup | input | 1 | 1 = supervisor-only page |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 16 | Virtual address |
| req_acc | input | 2 | 0 read, 1 write, 2 execute, 3 reserved |
| req_priv | input | 1 | 0 user, 1 supervisor |
| rsp_valid | output | 1 | Response present |
| rsp_fault | output | 1 | Response is a fault |
| rsp_cause | output | 2 | 0 none, 1 not valid, 2 access, 3 privilege |
| rsp_paddr | output | 32 | Physical address, zero on fault |

## Verification
The assertions check four things on every cycle:
- the one-cycle request-to-response timing;
- that the offset passes through on successful responses;
- that a fault always carries a cause and a zero address;
- that a configuration write lands in the entry it names.

The permission outcomes can only be shown by the bench's scenarios, because they depend on the table's contents. These outcomes are:
- the choice between the three causes and their priority;
- supervisor override on supervisor-only pages;
- the refusal of access code 3;
- the old-entry view when a write and a lookup share an edge;
- the clearing of the table by reset.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_t;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'd0,
        CAUSE_INVALID = 2'd1,
        CAUSE_ACCESS  = 2'd2,
        CAUSE_PRIV    = 2'd3
    } cause_t;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
        logic sup;
    } perm_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_MAPPED  = 2'd1,
        ST_FAULTED = 2'd2
    } rsp_state_t;

endpackage

// File: rtl/xlat_table.sv
module xlat_table
    import xlat_pkg::*;
#(
    parameter int VPN_W = 4,
    parameter int PPN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [VPN_W-1:0] cfg_idx,
    input  logic             cfg_valid,
    input  logic [PPN_W-1:0] cfg_ppn,
    input  perm_t            cfg_perm,
    input  logic [VPN_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [PPN_W-1:0] rd_ppn,
    output perm_t            rd_perm
);

    localparam int ENTRIES = 1 << VPN_W;

    logic             vld_q  [ENTRIES];
    logic [PPN_W-1:0] ppn_q  [ENTRIES];
    perm_t            perm_q [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        logic hit;
        assign hit = cfg_we && (cfg_idx == VPN_W'(e));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[e]  <= 1'b0;
                ppn_q[e]  <= '0;
                perm_q[e] <= '0;
            end else if (hit) begin
                vld_q[e]  <= cfg_valid;
                ppn_q[e]  <= cfg_ppn;
                perm_q[e] <= cfg_perm;
            end
        end
    end

    assign rd_valid = vld_q[rd_idx];
    assign rd_ppn   = ppn_q[rd_idx];
    assign rd_perm  = perm_q[rd_idx];

    AST_CFG_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (vld_q[$past(cfg_idx)] == $past(cfg_valid)
                    && ppn_q[$past(cfg_idx)] == $past(cfg_ppn))); // R9

endmodule

// File: rtl/xlat_check.sv
module xlat_check
    import xlat_pkg::*;
#(
    parameter int PPN_W = 20,
    parameter int OFF_W = 12
) (
    input  logic                   ent_valid,
    input  logic [PPN_W-1:0]       ent_ppn,
    input  perm_t                  ent_perm,
    input  logic [1:0]             acc,
    input  logic                   priv_sup,
    input  logic [OFF_W-1:0]       offset,
    output cause_t                 cause,
    output logic [PPN_W+OFF_W-1:0] paddr
);

    logic kind_ok;
    logic priv_ok;

    always_comb begin
        unique case (acc_t'(acc))
            ACC_READ:  kind_ok = ent_perm.rd;
            ACC_WRITE: kind_ok = ent_perm.wr;
            ACC_EXEC:  kind_ok = ent_perm.ex;
            default:   kind_ok = 1'b0;
        endcase
    end

    assign priv_ok = priv_sup || !ent_perm.sup;

    always_comb begin
        if (!ent_valid)
            cause = CAUSE_INVALID;
        else if (!kind_ok)
            cause = CAUSE_ACCESS;
        else if (!priv_ok)
            cause = CAUSE_PRIV;
        else
            cause = CAUSE_NONE;
    end

    assign paddr = {ent_ppn, offset};

endmodule

// File: rtl/page_xlate_unit.sv
module page_xlate_unit
    import xlat_pkg::*;
#(
    parameter int VA_W  = 16,
    parameter int OFF_W = 12,
    parameter int PPN_W = 20
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [VA_W-OFF_W-1:0]       cfg_idx,
    input  logic                        cfg_valid,
    input  logic [PPN_W-1:0]            cfg_ppn,
    input  logic                        cfg_rd,
    input  logic                        cfg_wr,
    input  logic                        cfg_ex,
    input  logic                        cfg_sup,
    input  logic                        req_valid,
    input  logic [VA_W-1:0]             req_vaddr,
    input  logic [1:0]                  req_acc,
    input  logic                        req_priv,
    output logic                        rsp_valid,
    output logic                        rsp_fault,
    output logic [1:0]                  rsp_cause,
    output logic [PPN_W+OFF_W-1:0]      rsp_paddr
);

    localparam int VPN_W = VA_W - OFF_W;
    localparam int PA_W  = PPN_W + OFF_W;

    logic             ent_valid;
    logic [PPN_W-1:0] ent_ppn;
    perm_t            ent_perm;
    perm_t            cfg_perm;
    cause_t           cause_d;
    logic [PA_W-1:0]  paddr_d;

    rsp_state_t       state_q, state_d;
    cause_t           cause_q;
    logic [PA_W-1:0]  paddr_q;

    assign cfg_perm = '{rd: cfg_rd, wr: cfg_wr, ex: cfg_ex, sup: cfg_sup};

    xlat_table #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_valid (cfg_valid),
        .cfg_ppn   (cfg_ppn),
        .cfg_perm  (cfg_perm),
        .rd_idx    (req_vaddr[VA_W-1:OFF_W]),
        .rd_valid  (ent_valid),
        .rd_ppn    (ent_ppn),
        .rd_perm   (ent_perm)
    );

    xlat_check #(.PPN_W(PPN_W), .OFF_W(OFF_W)) u_check (
        .ent_valid (ent_valid),
        .ent_ppn   (ent_ppn),
        .ent_perm  (ent_perm),
        .acc       (req_acc),
        .priv_sup  (req_priv),
        .offset    (req_vaddr[OFF_W-1:0]),
        .cause     (cause_d),
        .paddr     (paddr_d)
    );

    always_comb begin
        if (!req_valid)
            state_d = ST_IDLE;
        else if (cause_d == CAUSE_NONE)
            state_d = ST_MAPPED;
        else
            state_d = ST_FAULTED;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cause_q <= CAUSE_NONE;
            paddr_q <= '0;
        end else begin
            state_q <= state_d;
            cause_q <= cause_d;
            paddr_q <= paddr_d;
        end
    end

    always_comb begin
        rsp_valid = 1'b0;
        rsp_fault = 1'b0;
        rsp_cause = CAUSE_NONE;
        rsp_paddr = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_MAPPED: begin
                rsp_valid = 1'b1;
                rsp_paddr = paddr_q;
            end
            ST_FAULTED: begin
                rsp_valid = 1'b1;
                rsp_fault = 1'b1;
                rsp_cause = cause_q;
            end
            default: ;
        endcase
    end

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R7
    AST_NO_RSP_UNASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R7
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_fault
                       || rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0]))); // R1
    AST_FAULT_CAUSE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_cause != 2'd0 && rsp_paddr == '0)); // R8
    AST_OK_NO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> rsp_cause == 2'd0); // R7

endmodule

// File: tb/page_xlate_unit_test.sv
`timescale 1ns/1ps
module page_xlate_unit_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [3:0]  cfg_idx;
    logic        cfg_valid;
    logic [19:0] cfg_ppn;
    logic        cfg_rd, cfg_wr, cfg_ex, cfg_sup;
    logic        req_valid;
    logic [15:0] req_vaddr;
    logic [1:0]  req_acc;
    logic        req_priv;
    logic        rsp_valid, rsp_fault;
    logic [1:0]  rsp_cause;
    logic [31:0] rsp_paddr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    page_xlate_unit uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid),
        .cfg_ppn(cfg_ppn), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr),
        .cfg_ex(cfg_ex), .cfg_sup(cfg_sup),
        .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_acc(req_acc), .req_priv(req_priv),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_cause(rsp_cause), .rsp_paddr(rsp_paddr)
    );

    typedef struct packed {
        logic [15:0] va;
        logic [1:0]  acc;
        logic        sup;
        logic [1:0]  cause;
        logic [31:0] pa;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{16'hFEED, 2'd0, 1'b0, 2'd0, 32'h24680EED},
        '{16'hF123, 2'd1, 1'b0, 2'd0, 32'h24680123},
        '{16'hF000, 2'd2, 1'b0, 2'd2, 32'h0},
        '{16'h1ABC, 2'd2, 1'b0, 2'd0, 32'h0000AABC},
        '{16'h1ABC, 2'd1, 1'b0, 2'd2, 32'h0},
        '{16'h2345, 2'd0, 1'b0, 2'd3, 32'h0},
        '{16'h2345, 2'd1, 1'b1, 2'd0, 32'h1100B345},
        '{16'h2345, 2'd2, 1'b1, 2'd2, 32'h0},
        '{16'h0FFF, 2'd0, 1'b1, 2'd1, 32'h0},
        '{16'h4000, 2'd0, 1'b0, 2'd1, 32'h0},
        '{16'h5000, 2'd0, 1'b0, 2'd2, 32'h0},
        '{16'h3FFF, 2'd1, 1'b0, 2'd0, 32'h98765FFF},
        '{16'hF000, 2'd3, 1'b1, 2'd2, 32'h0}
    };

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic load(logic [3:0] i, logic v, logic [19:0] p,
                        logic r, logic w, logic x, logic s);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = i; cfg_valid = v; cfg_ppn = p;
        cfg_rd = r; cfg_wr = w; cfg_ex = x; cfg_sup = s;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic expect_rsp(string tag, logic [1:0] cause, logic [31:0] pa);
        check({tag, " valid"}, {31'd0, rsp_valid}, 32'd1);
        check({tag, " fault"}, {31'd0, rsp_fault}, {31'd0, cause != 2'd0});
        check({tag, " cause"}, {30'd0, rsp_cause}, {30'd0, cause});
        check({tag, " paddr"}, rsp_paddr, pa);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_valid = 1'b0;
        cfg_ppn = '0; cfg_rd = 1'b0; cfg_wr = 1'b0; cfg_ex = 1'b0;
        cfg_sup = 1'b0; req_valid = 1'b0; req_vaddr = '0;
        req_acc = '0; req_priv = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);

        load(4'h1, 1'b1, 20'h0000A, 1, 0, 1, 0);
        load(4'h2, 1'b1, 20'h1100B, 1, 1, 0, 1);
        load(4'h3, 1'b1, 20'h98765, 0, 1, 0, 0);
        load(4'h4, 1'b0, 20'h11111, 1, 1, 1, 0);
        load(4'h5, 1'b1, 20'h22222, 0, 0, 0, 1);
        load(4'hF, 1'b1, 20'h24680, 1, 1, 0, 0);

        // Table walk: R1 R2 R3 R4 R5 R6, responses back to back (R7)
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = VECS[0].va; req_acc = VECS[0].acc; req_priv = VECS[0].sup;
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            expect_rsp($sformatf("R1-table vec%0d", k), VECS[k].cause, VECS[k].pa);
            if (k + 1 < NV) begin
                req_vaddr = VECS[k+1].va; req_acc = VECS[k+1].acc;
                req_priv  = VECS[k+1].sup;
            end else begin
                req_valid = 1'b0;
            end
        end
        @(negedge clk);
        check("R7 idle after requests", {31'd0, rsp_valid}, 32'd0);

        // R9: write and lookup on the same edge, old entry seen
        cfg_we = 1'b1; cfg_idx = 4'hF; cfg_valid = 1'b1; cfg_ppn = 20'h00077;
        cfg_rd = 1'b1; cfg_wr = 1'b1; cfg_ex = 1'b0; cfg_sup = 1'b0;
        req_valid = 1'b1; req_vaddr = 16'hF010; req_acc = 2'd0; req_priv = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0;
        expect_rsp("R9 old entry", 2'd0, 32'h24680010);
        @(negedge clk);
        req_valid = 1'b0;
        expect_rsp("R9 new entry", 2'd0, 32'h00077010);

        // R10: reset clears the table
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R10 rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
        req_valid = 1'b1; req_vaddr = 16'h1ABC; req_acc = 2'd0; req_priv = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        expect_rsp("R10 cleared entry", 2'd1, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule